// File: doc/BRIEF.md
# PWM Fault Trip Latch

This block sits between a multi-channel PWM generator and the output pads. Each channel has a true output and a complementary output. Up to four external fault lines are watched. When any enabled fault line is seen active, the block latches a trip. While the trip is latched, every enabled channel is forced to a safe state. That state is a programmed level, chosen once for all true outputs and once for all complementary outputs. A global option can release those pins to high impedance instead of driving a level. The trip also raises a one-cycle interrupt request.

The trip is sticky. Fault lines that go quiet, or bounce, neither release it nor re-enter it on their own. Software releases it by writing zero to the trip flag, after checking whatever it needs to check. Configuration arrives through a small write-only register port. Every pad has a value signal and an output-enable signal.

Top module: `pwm_trip_guard`

## Requirements
- R1: Each fault line has its own enable bit. A trip is raised when at least one enabled line is high. A high level on a line whose enable bit is 0 never raises a trip.
- R2: Fault lines pass through a two-stage synchronizer. A line that is high at rising edge k sets the trip flag at edge k+2.
- R3: Once the trip flag is set, it stays 1 after the fault lines return low. Only a write of 0 to the flag clears it, and the flag then stays 0 while no enabled fault line is high.
- R4: A write of 1 to the flag bit has no effect. It neither sets a clear flag nor changes a set one.
- R5: A clear takes priority in its own cycle. If an enabled, synchronized fault line is still high, the flag is set again at the next edge, and the interrupt fires again.
- R6: `trip_irq` is high for exactly one cycle. That cycle is the first cycle in which `trip_flag` reads 1 after a trip.
- R7: A channel whose enable bit is 0 is not overridden by a trip. Both of its pads have output enable 0 and value 0, tripped or not.
- R8: During a trip without high impedance, each enabled channel drives output enable 1. Its true pad takes level-register bit 0 and its complementary pad takes level-register bit 1.
- R9: During a trip with level-register bit 2 set, both pads of every enabled channel have output enable 0 and value 0.
- R10: Outside a trip, an enabled channel has output enable 1 on both pads, and each pad copies its PWM input.
- R11: Synchronous active-high reset clears the flag, the interrupt and all enable and level bits. Every output enable and pad value is therefore 0 after reset.
- R12: The address selects the register written when `wr_en` is high:
  - 0: fault enables, bit n for line n
  - 1: channel enables, bit n for channel n
  - 2: levels, with bit 0 for the true pads, bit 1 for the complementary pads and bit 2 for high impedance
  - 3: trip flag, bit 0

  A write changes behaviour from the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_hi_in | input | NUM_CH | True PWM outputs from the generator |
| pwm_lo_in | input | NUM_CH | Complementary PWM outputs from the generator |
| fault_in | input | NUM_FLT | Asynchronous active-high fault lines |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | DATA_W | Register write data |
| pin_hi | output | NUM_CH | True pad values |
| pin_hi_oe | output | NUM_CH | True pad output enables |
| pin_lo | output | NUM_CH | Complementary pad values |
| pin_lo_oe | output | NUM_CH | Complementary pad output enables |
| trip_flag | output | 1 | Trip detected flag |
| trip_irq | output | 1 | One-cycle trip interrupt request |

## Verification
The bench builds the block with four channels, four fault lines and an 8-bit data port. Four channels is more than the default of three. With four channels, one vector can mix enabled and disabled channels with alternating PWM patterns. Each channel's pads are then checked against a distinct expected bit, so a crossed bit or a missed enable shows up. Using all four fault lines lets the bench put a high level on a disabled line next to an enabled one. It also lets the bench check that a line other than line 0 can trip the block.

// File: rtl/pwm_trip_pkg.sv
package pwm_trip_pkg;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_FLT_EN = 2'd0,
        REG_CH_EN  = 2'd1,
        REG_LEVEL  = 2'd2,
        REG_STATUS = 2'd3
    } reg_sel_e;

    localparam int LVL_HI_BIT = 0;
    localparam int LVL_LO_BIT = 1;
    localparam int TRI_BIT    = 2;
    localparam int FLAG_BIT   = 0;
endpackage

// File: rtl/fault_sync.sv
module fault_sync #(
    parameter int NUM_FLT = 4,
    parameter int STAGES  = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_FLT-1:0] fault_in,
    output logic [NUM_FLT-1:0] fault_sync_o
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0][NUM_FLT-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = fault_in;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign fault_sync_o = chain_q[LAST];
endmodule

// File: rtl/trip_ctrl.sv
module trip_ctrl
    import pwm_trip_pkg::*;
#(
    parameter int NUM_CH  = 3,
    parameter int NUM_FLT = 4,
    parameter int DATA_W  = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_FLT-1:0] flt_sync,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    output logic [NUM_CH-1:0]  ch_en,
    output logic               lvl_hi,
    output logic               lvl_lo,
    output logic               tri_en,
    output logic               trip_flag,
    output logic               trip_irq
);
    typedef struct packed {
        logic [NUM_FLT-1:0] flt_en;
        logic [NUM_CH-1:0]  ch_en;
        logic               lvl_hi;
        logic               lvl_lo;
        logic               tri_en;
        logic               flag;
        logic               irq;
    } ctl_state_t;

    ctl_state_t st_d, st_q;
    logic       hit_d;
    logic       clr_d;
    logic       unused_wr;

    assign unused_wr = ^wr_data;

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        clr_d    = 1'b0;
        hit_d    = |(flt_sync & st_q.flt_en);

        if (wr_en) begin
            case (reg_sel_e'(wr_addr))
                REG_FLT_EN: st_d.flt_en = wr_data[NUM_FLT-1:0];
                REG_CH_EN:  st_d.ch_en  = wr_data[NUM_CH-1:0];
                REG_LEVEL: begin
                    st_d.lvl_hi = wr_data[LVL_HI_BIT];
                    st_d.lvl_lo = wr_data[LVL_LO_BIT];
                    st_d.tri_en = wr_data[TRI_BIT];
                end
                REG_STATUS: clr_d = ~wr_data[FLAG_BIT];
                default: ;
            endcase
        end

        if (clr_d) begin
            st_d.flag = 1'b0;
        end else if (hit_d && !st_q.flag) begin
            st_d.flag = 1'b1;
            st_d.irq  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ch_en     = st_q.ch_en;
    assign lvl_hi    = st_q.lvl_hi;
    assign lvl_lo    = st_q.lvl_lo;
    assign tri_en    = st_q.tri_en;
    assign trip_flag = st_q.flag;
    assign trip_irq  = st_q.irq;
endmodule

// File: rtl/pin_drive.sv
module pin_drive #(
    parameter int NUM_CH = 3
) (
    input  logic              tripped,
    input  logic [NUM_CH-1:0] ch_en,
    input  logic              lvl_hi,
    input  logic              lvl_lo,
    input  logic              tri_en,
    input  logic [NUM_CH-1:0] pwm_hi,
    input  logic [NUM_CH-1:0] pwm_lo,
    output logic [NUM_CH-1:0] pin_hi,
    output logic [NUM_CH-1:0] pin_hi_oe,
    output logic [NUM_CH-1:0] pin_lo,
    output logic [NUM_CH-1:0] pin_lo_oe
);
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic hv, hoe, lv, loe;

        always_comb begin
            if (!ch_en[i]) begin
                hv  = 1'b0;
                hoe = 1'b0;
                lv  = 1'b0;
                loe = 1'b0;
            end else if (tripped) begin
                hoe = ~tri_en;
                loe = ~tri_en;
                hv  = lvl_hi & ~tri_en;
                lv  = lvl_lo & ~tri_en;
            end else begin
                hoe = 1'b1;
                loe = 1'b1;
                hv  = pwm_hi[i];
                lv  = pwm_lo[i];
            end
        end

        assign pin_hi[i]    = hv;
        assign pin_hi_oe[i] = hoe;
        assign pin_lo[i]    = lv;
        assign pin_lo_oe[i] = loe;
    end
endmodule

// File: rtl/pwm_trip_guard.sv
module pwm_trip_guard
    import pwm_trip_pkg::*;
#(
    parameter int NUM_CH      = 3,
    parameter int NUM_FLT     = 4,
    parameter int SYNC_STAGES = 2,
    parameter int DATA_W      = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_CH-1:0]  pwm_hi_in,
    input  logic [NUM_CH-1:0]  pwm_lo_in,
    input  logic [NUM_FLT-1:0] fault_in,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    output logic [NUM_CH-1:0]  pin_hi,
    output logic [NUM_CH-1:0]  pin_hi_oe,
    output logic [NUM_CH-1:0]  pin_lo,
    output logic [NUM_CH-1:0]  pin_lo_oe,
    output logic               trip_flag,
    output logic               trip_irq
);
    logic [NUM_FLT-1:0] flt_s;
    logic [NUM_CH-1:0]  ch_en_w;
    logic               lvl_hi_w, lvl_lo_w, tri_w;

    fault_sync #(.NUM_FLT(NUM_FLT), .STAGES(SYNC_STAGES)) u_sync (
        .clk         (clk),
        .rst         (rst),
        .fault_in    (fault_in),
        .fault_sync_o(flt_s)
    );

    trip_ctrl #(.NUM_CH(NUM_CH), .NUM_FLT(NUM_FLT), .DATA_W(DATA_W)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .flt_sync (flt_s),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .ch_en    (ch_en_w),
        .lvl_hi   (lvl_hi_w),
        .lvl_lo   (lvl_lo_w),
        .tri_en   (tri_w),
        .trip_flag(trip_flag),
        .trip_irq (trip_irq)
    );

    pin_drive #(.NUM_CH(NUM_CH)) u_pins (
        .tripped  (trip_flag),
        .ch_en    (ch_en_w),
        .lvl_hi   (lvl_hi_w),
        .lvl_lo   (lvl_lo_w),
        .tri_en   (tri_w),
        .pwm_hi   (pwm_hi_in),
        .pwm_lo   (pwm_lo_in),
        .pin_hi   (pin_hi),
        .pin_hi_oe(pin_hi_oe),
        .pin_lo   (pin_lo),
        .pin_lo_oe(pin_lo_oe)
    );
endmodule

// File: rtl/pwm_trip_guard_chk.sv
module pwm_trip_guard_chk #(
    parameter int NUM_CH = 3,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [1:0]        wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [NUM_CH-1:0] pwm_hi_in,
    input logic [NUM_CH-1:0] pin_hi,
    input logic [NUM_CH-1:0] pin_hi_oe,
    input logic [NUM_CH-1:0] pin_lo_oe,
    input logic              trip_flag,
    input logic              trip_irq
);
    logic clr_wr;
    logic past_rst = 1'b0;
    logic unused_chk;

    assign clr_wr     = wr_en && (wr_addr == 2'd3) && !wr_data[0];
    assign unused_chk = ^wr_data;

    // R3, R4: only a clearing write can drop the flag
    p_flag_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        trip_flag && !clr_wr |=> trip_flag);

    // R3: a clearing write always drops the flag at that edge
    p_clear_drops_r3: assert property (@(posedge clk) disable iff (rst)
        clr_wr |=> !trip_flag);

    p_irq_on_rise_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(trip_flag) |-> trip_irq);

    p_irq_single_r6: assert property (@(posedge clk) disable iff (rst)
        trip_irq |=> !trip_irq);

    p_irq_flag_r6: assert property (@(posedge clk) disable iff (rst)
        trip_irq |-> trip_flag);

    // R7, R9: both pads of a channel share one output-enable decision
    p_oe_pair_r7: assert property (@(posedge clk) disable iff (rst)
        pin_hi_oe == pin_lo_oe);

    p_pass_r10: assert property (@(posedge clk) disable iff (rst)
        !trip_flag |-> (((pin_hi ^ pwm_hi_in) & pin_hi_oe) == '0));

    always_ff @(posedge clk) begin
        past_rst <= rst;
        if (past_rst) begin
            a_reset_r11: assert (!trip_flag && !trip_irq && pin_hi_oe == '0 && pin_lo_oe == '0);
        end
    end
endmodule

bind pwm_trip_guard pwm_trip_guard_chk #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .pwm_hi_in(pwm_hi_in),
    .pin_hi   (pin_hi),
    .pin_hi_oe(pin_hi_oe),
    .pin_lo_oe(pin_lo_oe),
    .trip_flag(trip_flag),
    .trip_irq (trip_irq)
);

// File: tb/sim_pwm_trip_guard.sv
module sim_pwm_trip_guard;
    localparam int NCH = 4;
    localparam int NFL = 4;
    localparam int DW  = 8;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [NCH-1:0] pwm_hi_in = '0, pwm_lo_in = '0;
    logic [NFL-1:0] fault_in = '0;
    logic           wr_en = 1'b0;
    logic [1:0]     wr_addr = '0;
    logic [DW-1:0]  wr_data = '0;
    logic [NCH-1:0] pin_hi, pin_hi_oe, pin_lo, pin_lo_oe;
    logic           trip_flag, trip_irq;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    pwm_trip_guard #(.NUM_CH(NCH), .NUM_FLT(NFL), .SYNC_STAGES(2), .DATA_W(DW)) u0 (
        .clk(clk), .rst(rst), .pwm_hi_in(pwm_hi_in), .pwm_lo_in(pwm_lo_in),
        .fault_in(fault_in), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .pin_hi(pin_hi), .pin_hi_oe(pin_hi_oe), .pin_lo(pin_lo), .pin_lo_oe(pin_lo_oe),
        .trip_flag(trip_flag), .trip_irq(trip_irq)
    );

    // {ch_en, ctl(tri,lvl_lo,lvl_hi), trip, pwm_hi, pwm_lo, exp_hi, exp_hi_oe, exp_lo, exp_lo_oe}
    localparam logic [31:0] VEC [7] = '{
        {4'b1111, 3'b000, 1'b0, 4'b1010, 4'b0101, 4'b1010, 4'b1111, 4'b0101, 4'b1111},
        {4'b0110, 3'b011, 1'b0, 4'b1111, 4'b1111, 4'b0110, 4'b0110, 4'b0110, 4'b0110},
        {4'b1111, 3'b001, 1'b1, 4'b0000, 4'b1111, 4'b1111, 4'b1111, 4'b0000, 4'b1111},
        {4'b1111, 3'b010, 1'b1, 4'b1111, 4'b0000, 4'b0000, 4'b1111, 4'b1111, 4'b1111},
        {4'b0101, 3'b011, 1'b1, 4'b0000, 4'b0000, 4'b0101, 4'b0101, 4'b0101, 4'b0101},
        {4'b1111, 3'b111, 1'b1, 4'b1111, 4'b1111, 4'b0000, 4'b0000, 4'b0000, 4'b0000},
        {4'b1010, 3'b000, 1'b0, 4'b1110, 4'b0111, 4'b1010, 4'b1010, 4'b0010, 4'b1010}
    };

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        step();
        wr_en   = 1'b0;
    endtask

    task automatic check(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        pwm_hi_in = '1;
        pwm_lo_in = '1;
        repeat (3) step();
        rst = 1'b0;
        // R11: reset state
        check("R11", "hi_oe", 32'(pin_hi_oe), 0);
        check("R11", "lo_oe", 32'(pin_lo_oe), 0);
        check("R11", "hi", 32'(pin_hi), 0);
        check("R11", "flag", 32'(trip_flag), 0);
        check("R11", "irq", 32'(trip_irq), 0);

        // R12: a channel-enable write acts from the next edge
        wr(2'd1, 8'h03);
        check("R12", "hi_oe", 32'(pin_hi_oe), 32'h3);

        for (int v = 0; v < 7; v++) begin
            logic [31:0] e;
            string tag;
            e = VEC[v];
            tag = !e[24] ? "R10" : e[27] ? "R9" : (e[31:28] != 4'hF) ? "R7" : "R8";
            wr(2'd1, {4'b0, e[31:28]});
            wr(2'd2, {5'b0, e[27:25]});
            wr(2'd0, 8'h01);
            pwm_hi_in = e[23:20];
            pwm_lo_in = e[19:16];
            fault_in  = {3'b0, e[24]};
            repeat (4) step();
            check(tag, "pin_hi", 32'(pin_hi), 32'(e[15:12]));
            check(tag, "pin_hi_oe", 32'(pin_hi_oe), 32'(e[11:8]));
            check(tag, "pin_lo", 32'(pin_lo), 32'(e[7:4]));
            check(tag, "pin_lo_oe", 32'(pin_lo_oe), 32'(e[3:0]));
            fault_in = '0;
            repeat (3) step();
            wr(2'd3, 8'h00);
        end

        // R1: a disabled line never trips
        wr(2'd0, 8'h04);
        fault_in = 4'b0010;
        repeat (5) step();
        check("R1", "flag disabled line", 32'(trip_flag), 0);

        // R2: the synchronizer gives two edges of latency
        fault_in = 4'b0100;
        step();
        check("R2", "flag edge1", 32'(trip_flag), 0);
        step();
        check("R2", "flag edge2", 32'(trip_flag), 0);
        step();
        check("R2", "flag edge3", 32'(trip_flag), 1);
        check("R6", "irq rise", 32'(trip_irq), 1);
        step();
        check("R6", "irq one cycle", 32'(trip_irq), 0);

        // R3: the trip is sticky
        fault_in = '0;
        repeat (5) step();
        check("R3", "flag after fault low", 32'(trip_flag), 1);

        // R4: writing 1 has no effect
        wr(2'd3, 8'h01);
        check("R4", "flag kept", 32'(trip_flag), 1);
        wr(2'd3, 8'h00);
        check("R3", "flag cleared", 32'(trip_flag), 0);
        repeat (3) step();
        check("R3", "flag stays clear", 32'(trip_flag), 0);

        // R1: several lines enabled, a line other than line 0 trips
        wr(2'd0, 8'h0A);
        fault_in = 4'b1000;
        repeat (3) step();
        check("R1", "flag multi enable", 32'(trip_flag), 1);

        // R5: clearing while the fault is still high re-trips at once
        wr(2'd3, 8'h00);
        check("R5", "flag after clear", 32'(trip_flag), 0);
        step();
        check("R5", "flag re-entered", 32'(trip_flag), 1);
        check("R5", "irq re-entered", 32'(trip_irq), 1);

        fault_in = '0;
        repeat (3) step();
        wr(2'd3, 8'h00);
        wr(2'd3, 8'hFF);
        check("R4", "flag not set by write", 32'(trip_flag), 0);
        check("R4", "irq not set by write", 32'(trip_irq), 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule